// File: doc/BRIEF.md
# Dual Scanline Interrupt Comparator

This block raises two independent line-match interrupts for a raster display pipeline. Software programs one 32-bit configuration word that holds a line number for each channel. The block watches the raster line counter, the line-start strobe, the field parity flag and the interlace enable, all driven by the raster timing generator. Each channel pulses once per field when the raster reaches its programmed line.

The programmed line numbers count within a field. In progressive operation a channel matches the absolute line equal to its programmed value. In interlaced operation a value n matches absolute line 2n while the even field is scanned, and absolute line 2n+1 while the odd field is scanned. The comparison target is checked against the current total line count on every cycle. A change of the display total therefore takes effect at once, with no extra handshake.

Top module: `scanline_irq_pair`

## Requirements
- R1: A write to the configuration word stores `wdata & 0x03FF03FF` on the clock edge that samples `cfg_wr`. `cfg_rdata` returns the stored word from the next cycle on. Bits 25:16 hold the line for channel A, and bits 9:0 hold the line for channel B.
- R2: In progressive mode a channel whose programmed line is n responds when `line_start` is sampled high with `line_cnt == n`. It asserts its interrupt output for exactly the one cycle after that edge.
- R3: In interlaced mode with `field_odd` low, programmed line n matches absolute line 2n only. It does not match absolute line n.
- R4: In interlaced mode with `field_odd` high, programmed line n matches absolute line 2n+1 only.
- R5: If a channel's absolute target is greater than or equal to `total_lines`, that channel never fires. A target of `total_lines - 1` still fires.
- R6: After a channel fires, it stays silent until a field start, which is `line_start` with `line_cnt == 0`. It stays silent even if its target line is presented again.
- R7: If a channel is reprogrammed to a line at or before the current line, its next pulse comes in the following field.
- R8: A configuration write re-arms both channels. A channel that has already fired can therefore fire again in the same field at a later line.
- R9: Validity of the target is re-evaluated against the present `total_lines`. If the total is raised above a target that was out of range, the channel can fire within the same field.
- R10: The two channels act independently, and both can pulse on the same cycle.
- R11: During and right after reset, both interrupt outputs and `cfg_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Stored configuration word |
| line_cnt | input | 11 | Current absolute raster line |
| line_start | input | 1 | High on the first dot of each line |
| field_odd | input | 1 | 1 while the odd field is scanned |
| interlace_en | input | 1 | 1 selects interlaced mapping |
| total_lines | input | 11 | Number of lines per field pass |
| irq_a | output | 1 | Channel A line-match pulse |
| irq_b | output | 1 | Channel B line-match pulse |

## Verification
The bench drives the interlaced mapping in both fields with targets whose raw value also appears as a line. A design that skipped the doubling, or used the wrong parity, would pulse on the raw line or in the wrong field. It places targets exactly at `total_lines` and one below it, where an off-by-one range check either fires on an unreachable line or misses the last line. It presents a target line twice within one field, reprograms targets behind and ahead of the raster, and raises the total while a target is pending. A design without a correct arming flag would fire twice in one field, miss the re-armed match, or fire early after a backward reprogram.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;

  parameter int unsigned LINE_W  = 10;
  parameter int unsigned ABS_W   = LINE_W + 1;
  parameter int unsigned N_CHAN  = 2;
  parameter int unsigned WORD_W  = 32;
  parameter int unsigned HI_LSB  = 16;

  typedef logic [LINE_W-1:0] prog_line_t;
  typedef logic [ABS_W-1:0]  abs_line_t;

  // Width mask for one line field, and the full word mask.
  function automatic logic [WORD_W-1:0] field_mask();
    return WORD_W'((64'd1 << LINE_W) - 64'd1);
  endfunction

  function automatic logic [WORD_W-1:0] word_mask();
    return (field_mask() << HI_LSB) | field_mask();
  endfunction

  // Field-relative line to absolute raster line.
  function automatic abs_line_t field_target(prog_line_t n, logic ilace, logic odd);
    if (ilace) return {n, odd};
    return {1'b0, n};
  endfunction

  // A target is reachable only below the line total.
  function automatic logic target_reachable(abs_line_t tgt, abs_line_t total);
    return tgt < total;
  endfunction

endpackage

// File: rtl/scanline_irq_cfg.sv
module scanline_irq_cfg
  import scanline_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] cfg_q,
  output prog_line_t        line_hi,
  output prog_line_t        line_lo,
  output logic              rearm
);

  localparam logic [WORD_W-1:0] MASK = word_mask();

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr_en) cfg_q <= wr_data & MASK;
  end

  assign line_hi = cfg_q[HI_LSB +: LINE_W];
  assign line_lo = cfg_q[0 +: LINE_W];
  assign rearm   = wr_en;

  assert_cfg_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q == ($past(wr_data) & 32'h03FF03FF)));

endmodule

// File: rtl/scanline_irq_chan.sv
module scanline_irq_chan
  import scanline_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  prog_line_t prog_line,
  input  abs_line_t  line_cnt,
  input  logic       line_start,
  input  logic       field_odd,
  input  logic       interlace,
  input  abs_line_t  total_lines,
  input  logic       rearm,
  output logic       irq
);

  abs_line_t tgt_abs;
  logic      tgt_ok;
  logic      field_start;
  logic      armed;
  logic      armed_eff;
  logic      hit;

  always_comb begin
    tgt_abs     = field_target(prog_line, interlace, field_odd);
    tgt_ok      = target_reachable(tgt_abs, total_lines);
    field_start = line_start && (line_cnt == '0);
    armed_eff   = armed || field_start;
    hit         = line_start && armed_eff && tgt_ok && (line_cnt == tgt_abs);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b1;
      irq   <= 1'b0;
    end else begin
      irq <= hit;
      if (rearm)            armed <= 1'b1;
      else if (hit)         armed <= 1'b0;
      else if (field_start) armed <= 1'b1;
    end
  end

  // R2: a pulse follows a line start on the target line
  assert_match_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(line_start) && ($past(line_cnt) == $past(tgt_abs))));

  // R3 / R4: in interlaced mode the matched line parity follows the field
  assert_field_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(interlace)) |-> ($past(line_cnt[0]) == $past(field_odd)));

  assert_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(line_cnt) < $past(total_lines)));

endmodule

// File: rtl/scanline_irq_pair.sv
module scanline_irq_pair
  import scanline_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic [ABS_W-1:0]  line_cnt,
  input  logic              line_start,
  input  logic              field_odd,
  input  logic              interlace_en,
  input  logic [ABS_W-1:0]  total_lines,
  output logic              irq_a,
  output logic              irq_b
);

  prog_line_t line_sel [N_CHAN];
  logic [N_CHAN-1:0] irq_vec;
  logic rearm;

  scanline_irq_cfg cfg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_data (cfg_wdata),
    .cfg_q   (cfg_rdata),
    .line_hi (line_sel[0]),
    .line_lo (line_sel[1]),
    .rearm   (rearm)
  );

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    scanline_irq_chan chan_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .prog_line   (line_sel[c]),
      .line_cnt    (line_cnt),
      .line_start  (line_start),
      .field_odd   (field_odd),
      .interlace   (interlace_en),
      .total_lines (total_lines),
      .rearm       (rearm),
      .irq         (irq_vec[c])
    );
  end

  assign irq_a = irq_vec[0];
  assign irq_b = irq_vec[1];

  assert_reset_quiet_R11: assert property (@(posedge clk)
    $past(!rst_n) |-> (!irq_a && !irq_b && (cfg_rdata == '0)));

endmodule

// File: tb/scanline_irq_pair_tb_top.sv
`timescale 1ns/1ps
module scanline_irq_pair_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [10:0] line_cnt = '0;
  logic        line_start = 1'b0;
  logic        field_odd = 1'b0;
  logic        interlace_en = 1'b0;
  logic [10:0] total_lines = 11'd600;
  logic        irq_a, irq_b;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  scanline_irq_pair dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .line_cnt(line_cnt), .line_start(line_start),
    .field_odd(field_odd), .interlace_en(interlace_en),
    .total_lines(total_lines), .irq_a(irq_a), .irq_b(irq_b)
  );

  // {ilace, odd, total[11], line[11], a[10], b[10], exp_a, exp_b}
  localparam int NV = 11;
  localparam logic [45:0] VEC [NV] = '{
    {1'b0, 1'b0, 11'd600, 11'd5,   10'd5,   10'd9,   1'b1, 1'b0}, // R2
    {1'b0, 1'b0, 11'd600, 11'd9,   10'd5,   10'd9,   1'b0, 1'b1}, // R2
    {1'b0, 1'b0, 11'd600, 11'd7,   10'd7,   10'd7,   1'b1, 1'b1}, // R10
    {1'b1, 1'b0, 11'd600, 11'd6,   10'd3,   10'd6,   1'b1, 1'b0}, // R3
    {1'b1, 1'b1, 11'd600, 11'd7,   10'd3,   10'd7,   1'b1, 1'b0}, // R4
    {1'b1, 1'b1, 11'd600, 11'd6,   10'd3,   10'd6,   1'b0, 1'b0}, // R4
    {1'b1, 1'b0, 11'd600, 11'd3,   10'd3,   10'd1,   1'b0, 1'b0}, // R3
    {1'b0, 1'b0, 11'd10,  11'd10,  10'd10,  10'd1,   1'b0, 1'b0}, // R5
    {1'b0, 1'b0, 11'd10,  11'd9,   10'd9,   10'd9,   1'b1, 1'b1}, // R5
    {1'b1, 1'b1, 11'd525, 11'd525, 10'd262, 10'd261, 1'b0, 1'b0}, // R5
    {1'b1, 1'b0, 11'd525, 11'd522, 10'd261, 10'd1,   1'b1, 1'b0}  // R3
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [9:0] a, logic [9:0] b);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = {6'h3F, a, 6'h3F, b};
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Present one line start; returns with irq outputs of that edge visible.
  task automatic line_step(logic [10:0] ln);
    @(negedge clk);
    line_cnt = ln;
    line_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    line_start = 1'b0;
  endtask

  task automatic expect_irq(string tag, logic ea, logic eb);
    check({tag, " irq_a"}, {31'd0, irq_a}, {31'd0, ea});
    check({tag, " irq_b"}, {31'd0, irq_b}, {31'd0, eb});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_irq("R11 in reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 rdata after reset", cfg_rdata, 32'h0);
    expect_irq("R11 after reset", 1'b0, 1'b0);

    // R1 masking and readback
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
    @(posedge clk); @(negedge clk); cfg_wr = 1'b0;
    check("R1 all ones", cfg_rdata, 32'h03FF_03FF);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 32'hA5A5_A5A5;
    @(posedge clk); @(negedge clk); cfg_wr = 1'b0;
    check("R1 pattern", cfg_rdata, 32'h01A5_01A5);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [45:0] v;
      v = VEC[i];
      @(negedge clk);
      interlace_en = v[45];
      field_odd    = v[44];
      total_lines  = v[43:33];
      cfg_write(v[21:12], v[11:2]);
      line_step(v[32:22]);
      expect_irq($sformatf("R2-R5/R10 vector %0d", i), v[1], v[0]);
    end

    @(negedge clk);
    interlace_en = 1'b0; field_odd = 1'b0; total_lines = 11'd600;

    // R6 once per field
    cfg_write(10'd5, 10'd1023);
    line_step(11'd0);  expect_irq("R6 field start", 1'b0, 1'b0);
    line_step(11'd5);  expect_irq("R6 first match", 1'b1, 1'b0);
    @(negedge clk);    expect_irq("R2 pulse one cycle", 1'b0, 1'b0);
    line_step(11'd5);  expect_irq("R6 repeat line", 1'b0, 1'b0);
    line_step(11'd0);  expect_irq("R6 new field", 1'b0, 1'b0);
    line_step(11'd5);  expect_irq("R6 next field", 1'b1, 1'b0);

    // R7 reprogram at or behind the raster
    line_step(11'd0);
    line_step(11'd6);
    cfg_write(10'd6, 10'd1023);
    line_step(11'd7);  expect_irq("R7 equal line later", 1'b0, 1'b0);
    cfg_write(10'd2, 10'd1023);
    line_step(11'd9);  expect_irq("R7 behind line", 1'b0, 1'b0);
    line_step(11'd0);  expect_irq("R7 field start", 1'b0, 1'b0);
    line_step(11'd2);  expect_irq("R7 next field", 1'b1, 1'b0);

    // R8 write re-arms within a field
    cfg_write(10'd5, 10'd1023);
    line_step(11'd0);
    line_step(11'd5);  expect_irq("R8 first", 1'b1, 1'b0);
    cfg_write(10'd9, 10'd1023);
    line_step(11'd9);  expect_irq("R8 re-armed", 1'b1, 1'b0);

    // R9 total raised while target pending
    @(negedge clk); total_lines = 11'd12;
    cfg_write(10'd12, 10'd1023);
    line_step(11'd0);
    line_step(11'd12); expect_irq("R9 out of range", 1'b0, 1'b0);
    @(negedge clk); total_lines = 11'd13;
    line_step(11'd12); expect_irq("R9 total raised", 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule